// File: doc/BRIEF.md
# Instruction TLB Replacement Tracker

This block keeps recency state for a four-way, fully associative instruction translation buffer, and picks which way to overwrite when a translation found in the larger shared buffer has to be copied in. The recency state is six bits. Each bit records the relative age of one pair of ways. Every use of a way rewrites the bits of the three pairs that contain that way, and leaves the other three bits alone.

Two kinds of request drive the block. A hit strobe with a way index reports that the instruction lookup matched that way. A fill strobe with a complete entry asks for that entry to be stored. On a fill, the block writes the entry into the way that was used least recently, through a write strobe, index and data that go to the entry array. In the same cycle it marks that way as the most recently used.

Top module: `itlb_plru_repl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `lru_state` to 6'b000000 and clears `state_err`. From that state the victim is way 3.
- R2: Each bit of `lru_state` is 1 when the second way of its pair is newer than the first. The pairs are bit 5 = (0,1), bit 4 = (0,2), bit 3 = (0,3), bit 2 = (1,2), bit 1 = (1,3), bit 0 = (2,3). A use of way 0 clears bits 5,4,3. A use of way 1 sets bit 5 and clears bits 2,1. A use of way 2 sets bits 4 and 2 and clears bit 0. A use of way 3 sets bits 3,1,0. The change is visible after the clock edge.
- R3: A use leaves unchanged the three bits that do not involve the used way.
- R4: `victim_idx` is combinational from `lru_state`. The rules are tried in order, and the first match wins. Way 0 if bits 5,4,3 are all 1. Else way 1 if bit 5 is 0 and bits 2,1 are 1. Else way 2 if bits 4,2 are 0 and bit 0 is 1. Else way 3 if bits 3,1,0 are all 0.
- R5: While `fill_valid` is high, `wr_en` is high in the same cycle, with `wr_idx` equal to `victim_idx` and `wr_data` equal to `fill_entry`. `wr_en` is low whenever `fill_valid` is low.
- R6: At the clock edge that ends a fill, the victim way is marked used as in R2, so the next victim differs from the way just written.
- R7: When `fill_valid` and `hit_valid` are both high, the fill is served and the hit has no effect on `lru_state`.
- R8: With neither strobe high, `lru_state` holds its value.
- R9: `state_err` is set at a clock edge when `lru_state` matches none of the R4 rules. It stays set until reset. A fill in such a state gives no write and no update. Any sequence of hits and fills that starts from reset leaves `state_err` at 0.
- R10: After any sequence of uses, `victim_idx` is the way whose most recent use is the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_valid | input | 1 | Instruction lookup hit strobe |
| hit_idx | input | 2 | Way that hit |
| fill_valid | input | 1 | Request to store a new entry |
| fill_entry | input | ENTRY_W | Entry to store |
| lru_state | output | 6 | Pairwise recency bits |
| victim_idx | output | 2 | Way chosen for replacement |
| state_err | output | 1 | Sticky flag for a state that matches no victim rule |
| wr_en | output | 1 | Entry array write strobe |
| wr_idx | output | 2 | Entry array write way |
| wr_data | output | ENTRY_W | Entry array write data |

## Verification
The bench starts with a single hit on each way from reset. This shows whether each way's own set and clear pattern lands on the right bits and leaves the other three bits alone. Runs of fills follow, with nothing in between, and they must rotate through all four ways. This tells apart a victim decode that respects the rule order from one that rereads a stale state. Cycles with both strobes high show whether the hit index leaks into the update. A long pseudo-random mix of hits, fills and idle cycles is compared against an age-ranked model of the four ways. It shows that the victim is always the oldest way and that the error flag never rises.

// File: rtl/itlb_plru_repl.sv
module itlb_plru_repl #(
  parameter int ENTRY_W = 48,
  localparam int WAYS = 4,
  localparam int IDX_W = $clog2(WAYS),
  localparam int LRU_W = WAYS * (WAYS - 1) / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_valid,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic               fill_valid,
  input  logic [ENTRY_W-1:0] fill_entry,
  output logic [LRU_W-1:0]   lru_state,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               state_err,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [ENTRY_W-1:0] wr_data
);

  logic [LRU_W-1:0] lru_q, lru_d;
  logic [WAYS-1:0]  pick;
  logic             state_ok;
  logic             use_en;
  logic [IDX_W-1:0] use_idx;
  logic             err_q;

  assign pick[0] =  lru_q[5] &  lru_q[4] &  lru_q[3];
  assign pick[1] = ~lru_q[5] &  lru_q[2] &  lru_q[1];
  assign pick[2] = ~lru_q[4] & ~lru_q[2] &  lru_q[0];
  assign pick[3] = ~lru_q[3] & ~lru_q[1] & ~lru_q[0];
  assign state_ok = |pick;

  always_comb begin
    if (pick[0])      victim_idx = 2'd0;
    else if (pick[1]) victim_idx = 2'd1;
    else if (pick[2]) victim_idx = 2'd2;
    else              victim_idx = 2'd3;
  end

  assign wr_en   = fill_valid & state_ok;
  assign wr_idx  = victim_idx;
  assign wr_data = fill_entry;

  assign use_en  = fill_valid ? state_ok : hit_valid;
  assign use_idx = fill_valid ? victim_idx : hit_idx;

  always_comb begin
    lru_d = lru_q;
    if (use_en) begin
      unique case (use_idx)
        2'd0: lru_d[5:3] = 3'b000;
        2'd1: begin lru_d[5] = 1'b1; lru_d[2:1] = 2'b00; end
        2'd2: begin lru_d[4] = 1'b1; lru_d[2] = 1'b1; lru_d[0] = 1'b0; end
        default: begin lru_d[3] = 1'b1; lru_d[1:0] = 2'b11; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
      err_q <= 1'b0;
    end else begin
      lru_q <= lru_d;
      if (!state_ok) err_q <= 1'b1;
    end
  end

  assign lru_state = lru_q;
  assign state_err = err_q;

endmodule

module itlb_plru_repl_chk #(
  parameter int ENTRY_W = 48
) (
  input logic               clk,
  input logic               rst,
  input logic               hit_valid,
  input logic [1:0]         hit_idx,
  input logic               fill_valid,
  input logic [ENTRY_W-1:0] fill_entry,
  input logic [5:0]         lru_state,
  input logic [1:0]         victim_idx,
  input logic               state_err,
  input logic               wr_en,
  input logic [1:0]         wr_idx,
  input logic [ENTRY_W-1:0] wr_data
);

  // R5
  wr_needs_fill_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (fill_valid && wr_data == fill_entry && wr_idx == victim_idx));

  // R6
  fill_moves_victim_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> victim_idx != $past(wr_idx));

  // R8
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit_valid && !fill_valid) |=> $stable(lru_state));

  // R2
  hit_way0_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_valid && !fill_valid && hit_idx == 2'd0) |=> lru_state[5:3] == 3'b000);

  // R10
  hit_not_victim_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_valid && !fill_valid) |=> victim_idx != $past(hit_idx));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    state_err |=> state_err);

  // R9
  err_never_chk: assert property (@(posedge clk) disable iff (rst)
    !state_err);

endmodule

bind itlb_plru_repl itlb_plru_repl_chk #(.ENTRY_W(ENTRY_W)) u_chk (
  .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_idx(hit_idx),
  .fill_valid(fill_valid), .fill_entry(fill_entry), .lru_state(lru_state),
  .victim_idx(victim_idx), .state_err(state_err), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/itlb_plru_repl_bench.sv
`timescale 1ns/100ps
module itlb_plru_repl_bench;
  localparam int W = 48;

  logic         clk = 1'b0;
  logic         rst;
  logic         hit_valid, fill_valid;
  logic [1:0]   hit_idx;
  logic [W-1:0] fill_entry;
  logic [5:0]   lru_state;
  logic [1:0]   victim_idx, wr_idx;
  logic         state_err, wr_en;
  logic [W-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  int rank [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  itlb_plru_repl #(.ENTRY_W(W)) u_itlb_plru_repl (
    .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_idx(hit_idx),
    .fill_valid(fill_valid), .fill_entry(fill_entry), .lru_state(lru_state),
    .victim_idx(victim_idx), .state_err(state_err), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model_bits();
    logic [5:0] b;
    b[5] = rank[1] < rank[0];
    b[4] = rank[2] < rank[0];
    b[3] = rank[3] < rank[0];
    b[2] = rank[2] < rank[1];
    b[1] = rank[3] < rank[1];
    b[0] = rank[3] < rank[2];
    return b;
  endfunction

  function automatic logic [1:0] model_victim();
    logic [1:0] v = 2'd0;
    for (int j = 0; j < 4; j++) if (rank[j] == 3) v = 2'(j);
    return v;
  endfunction

  task automatic model_use(input int e);
    for (int j = 0; j < 4; j++) if (rank[j] < rank[e]) rank[j]++;
    rank[e] = 0;
  endtask

  task automatic model_reset();
    for (int j = 0; j < 4; j++) rank[j] = j;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); #0.5;
    @(posedge clk); #0.5;
    rst = 1'b0;
    model_reset();
  endtask

  task automatic step(input logic h, input logic [1:0] hi, input logic f,
                      input logic [W-1:0] d, input string req);
    logic [1:0] v;
    hit_valid = h; hit_idx = hi; fill_valid = f; fill_entry = d;
    #1;
    v = model_victim();
    check({req, " R5 wr_en"}, 64'(wr_en), 64'(f));
    if (f) begin
      check({req, " R5 wr_idx"}, 64'(wr_idx), 64'(v));
      check({req, " R5 wr_data"}, 64'(wr_data), 64'(d));
    end
    @(posedge clk); #0.5;
    if (f) model_use(v);
    else if (h) model_use(hi);
    hit_valid = 0; fill_valid = 0;
    check({req, " lru_state"}, 64'(lru_state), 64'(model_bits()));
    check({req, " R4 victim_idx"}, 64'(victim_idx), 64'(model_victim()));
    check({req, " R9 state_err"}, 64'(state_err), 64'd0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 lru_state after reset", 64'(lru_state), 64'd0);
    check("R1 victim after reset", 64'(victim_idx), 64'd3);
    check("R1 state_err after reset", 64'(state_err), 64'd0);
    check("R5 wr_en idle", 64'(wr_en), 64'd0);
  endtask

  task automatic t_single_hits();
    logic [5:0] exp [4];
    exp[0] = 6'b000000; exp[1] = 6'b100000; exp[2] = 6'b010100; exp[3] = 6'b001011;
    for (int k = 0; k < 4; k++) begin
      do_reset();
      step(1'b1, 2'(k), 1'b0, '0, "R2 single hit");
      check("R2 R3 exact pattern", 64'(lru_state), 64'(exp[k]));
    end
  endtask

  task automatic t_fill_rotation();
    logic [1:0] first;
    do_reset();
    for (int k = 0; k < 8; k++) begin
      first = victim_idx;
      step(1'b0, 2'd0, 1'b1, W'(64'h1000 + k), "R6 fill run");
      check("R6 victim moved", 64'(victim_idx != first), 64'd1);
    end
  endtask

  task automatic t_both();
    do_reset();
    step(1'b1, 2'd1, 1'b0, '0, "R7 setup");
    step(1'b1, 2'd3, 1'b1, W'(64'hABCDEF), "R7 fill+hit");
    step(1'b1, 2'd0, 1'b1, W'(64'h123456), "R7 fill+hit2");
  endtask

  task automatic t_idle();
    logic [5:0] s;
    do_reset();
    step(1'b1, 2'd2, 1'b0, '0, "R8 setup");
    s = lru_state;
    for (int k = 0; k < 3; k++) step(1'b0, 2'd1, 1'b0, '0, "R8 idle");
    check("R8 held", 64'(lru_state), 64'(s));
  endtask

  task automatic t_random();
    logic [15:0] lf = 16'hACE1;
    do_reset();
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[2:1], lf[3] & lf[4], W'({lf, lf}), "R10 random");
    end
    rst = 1'b1;
    @(posedge clk); #0.5;
    rst = 1'b0;
    model_reset();
    check("R1 mid-run reset", 64'(lru_state), 64'd0);
  endtask

  initial begin
    rst = 1'b1; hit_valid = 0; hit_idx = 0; fill_valid = 0; fill_entry = '0;
    model_reset();
    @(negedge clk);
    t_reset();
    t_single_hits();
    t_fill_rotation();
    t_both();
    t_idle();
    t_random();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule